// File: doc/BRIEF.md
# Partitioned Saturating Lane Adder

This block adds or subtracts two 64-bit operands that are split into independent lanes. A lane-width select splits the datapath into eight 8-bit, four 16-bit or two 32-bit lanes. No carry passes from one lane into the next. A subtract control turns every lane into a difference. Two more controls set how each lane reads its operands, signed or unsigned, and what it does on overflow. In wrap mode a lane keeps its modulo result. In saturating mode it clamps to the nearest extreme value it can hold.

Every lane raises its own overflow flag in both modes, so the flag also shows when a lane was clipped. The operands and controls are captured when `in_valid_i` is high. The packed result and the flags appear on registered outputs one clock later, with `out_valid_o` marking them.

Top module: `psimd_add`

## Requirements
- R1: `lane_mode_i` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane k covers bits k*w to k*w+w-1. No carry or borrow crosses from one lane into the next.
- R2: With `sub_i`=1 each lane computes a minus b, formed as a plus the bitwise inverse of b plus one. With `sub_i`=0 each lane computes a plus b.
- R3: With `sat_i`=0 every lane outputs its sum or difference modulo 2^w, whether or not it overflowed.
- R4: Unsigned overflow (`signed_i`=0) is a carry out of the lane's top bit for add, and a borrow (a < b) for subtract.
- R5: Signed overflow (`signed_i`=1) is flagged only in these cases. An add overflows when both operands have the same sign and the result sign differs from it. A subtract overflows when the operand signs differ and the result sign differs from a's sign. An add with mixed signs never overflows.
- R6: With `sat_i`=1 and `signed_i`=0, an overflowing lane outputs all ones for add and zero for subtract.
- R7: With `sat_i`=1 and `signed_i`=1, an overflowing lane outputs the most positive lane value (0 then all ones) when a is non-negative. It outputs the most negative value (1 then all zeros) when a is negative.
- R8: `ovf_o` bit k is the flag of lane k. It is set in both wrap and saturate modes. Flag bits at or above the current lane count read 0.
- R9: `out_valid_o` is `in_valid_i` delayed by exactly one clock. `result_o` and `ovf_o` load only on a cycle with `in_valid_i`=1 and hold their value otherwise.
- R10: While `rst_ni` is low, `out_valid_o`, `result_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and controls are valid this cycle |
| lane_mode_i | input | 2 | Lane width select (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| sat_i | input | 1 | 1 = saturate, 0 = wrap |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| out_valid_o | output | 1 | Result registers hold a new result |
| result_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-lane overflow flags, lane 0 in bit 0 |

## Verification
The assertions check the following on every cycle:
- The valid delay and the hold of the result registers.
- That the lowest 8-bit lane wraps to the modulo sum in wrap mode.
- That an unsigned 8-bit difference that borrows saturates to zero with its flag set.
- That a signed add with mixed signs never flags.
- That the upper half of the 32-bit lanes is free of carries from the lower half.
- That unused flag bits stay clear in the wider modes.

Other behaviours show only in the bench's scenarios:
- The signed clamp direction.
- Flag placement in every lane width.
- Borrow isolation between lanes.
- The treatment of lane-mode code 3.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [1:0] {
    LANES_8B   = 2'd0,
    LANES_16B  = 2'd1,
    LANES_32B  = 2'd2,
    LANES_32BX = 2'd3
  } lane_mode_e;

  // log2 of slices per lane; code 3 aliases the 32-bit layout
  function automatic logic [1:0] lane_shift(lane_mode_e m);
    case (m)
      LANES_8B:  return 2'd0;
      LANES_16B: return 2'd1;
      default:   return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/psimd_lane_map.sv
module psimd_lane_map
  import psimd_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  localparam int IDX_W = $clog2(NUM_SLICES)
) (
  input  logic [1:0]            lane_mode_i,
  output logic [1:0]            shift_o,
  output logic [IDX_W-1:0]      span_m1_o,
  output logic [NUM_SLICES-1:0] cut_o
);

  always_comb begin
    shift_o   = lane_shift(lane_mode_e'(lane_mode_i));
    span_m1_o = IDX_W'((32'd1 << shift_o) - 32'd1);
  end

  // slice i starts a new lane when its low index bits are zero
  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_cut
    assign cut_o[i] = ((IDX_W'(i) & span_m1_o) == '0);
  end

endmodule

// File: rtl/psimd_carry_chain.sv
module psimd_carry_chain #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  localparam int DATA_W = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  input  logic                  sub_i,
  input  logic [NUM_SLICES-1:0] cut_i,
  output logic [DATA_W-1:0]     sum_o,
  output logic [NUM_SLICES-1:0] cout_o
);

  logic [NUM_SLICES-1:0] cin;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    logic [SLICE_W-1:0] bx;
    logic [SLICE_W:0]   s;

    if (i == 0) begin : g_first
      assign cin[i] = sub_i;
    end else begin : g_link
      // lane start injects the subtract +1, otherwise ripple
      assign cin[i] = cut_i[i] ? sub_i : cout_o[i-1];
    end

    assign bx = b_i[i*SLICE_W +: SLICE_W] ^ {SLICE_W{sub_i}};
    assign s  = {1'b0, a_i[i*SLICE_W +: SLICE_W]} + {1'b0, bx} + {{SLICE_W{1'b0}}, cin[i]};
    assign sum_o[i*SLICE_W +: SLICE_W] = s[SLICE_W-1:0];
    assign cout_o[i] = s[SLICE_W];
  end

endmodule

// File: rtl/psimd_lane_ctl.sv
module psimd_lane_ctl #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  localparam int DATA_W = SLICE_W * NUM_SLICES,
  localparam int IDX_W  = $clog2(NUM_SLICES)
) (
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  input  logic [DATA_W-1:0]     sum_i,
  input  logic [NUM_SLICES-1:0] cout_i,
  input  logic [1:0]            shift_i,
  input  logic [IDX_W-1:0]      span_m1_i,
  input  logic                  sub_i,
  input  logic                  sat_i,
  input  logic                  signed_i,
  output logic [DATA_W-1:0]     res_o,
  output logic [NUM_SLICES-1:0] ovf_o
);

  // overflow if slice j were the top of its lane
  logic [NUM_SLICES-1:0] top_ovf;
  logic [NUM_SLICES-1:0] top_sa;

  for (genvar j = 0; j < NUM_SLICES; j++) begin : g_top
    logic sa, sb, sr, u_ovf, s_ovf;
    assign sa    = a_i[j*SLICE_W + SLICE_W-1];
    assign sb    = b_i[j*SLICE_W + SLICE_W-1];
    assign sr    = sum_i[j*SLICE_W + SLICE_W-1];
    assign u_ovf = sub_i ? ~cout_i[j] : cout_i[j];
    assign s_ovf = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    assign top_ovf[j] = signed_i ? s_ovf : u_ovf;
    assign top_sa[j]  = sa;
  end

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_res
    logic [IDX_W-1:0]   top;
    logic               lane_ovf;
    logic               at_top;
    logic [SLICE_W-1:0] clamp;

    assign top      = IDX_W'(i) | span_m1_i;
    assign lane_ovf = top_ovf[top];
    assign at_top   = (top == IDX_W'(i));

    always_comb begin
      if (!signed_i) begin
        clamp = {SLICE_W{~sub_i}};
      end else if (top_sa[top]) begin
        clamp = at_top ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
      end else begin
        clamp = at_top ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
      end
    end

    assign res_o[i*SLICE_W +: SLICE_W] =
      (sat_i && lane_ovf) ? clamp : sum_i[i*SLICE_W +: SLICE_W];
  end

  // pack lane flags from bit 0 upward
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_flag
    logic [IDX_W:0]   n_lanes;
    logic [IDX_W-1:0] src;
    assign n_lanes  = (IDX_W+1)'(NUM_SLICES) >> shift_i;
    assign src      = IDX_W'(k << shift_i) | span_m1_i;
    assign ovf_o[k] = ((IDX_W+1)'(k) < n_lanes) ? top_ovf[src] : 1'b0;
  end

endmodule

// File: rtl/psimd_add.sv
module psimd_add #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  localparam int DATA_W = SLICE_W * NUM_SLICES,
  localparam int IDX_W  = $clog2(NUM_SLICES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [1:0]            lane_mode_i,
  input  logic                  sub_i,
  input  logic                  sat_i,
  input  logic                  signed_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  output logic                  out_valid_o,
  output logic [DATA_W-1:0]     result_o,
  output logic [NUM_SLICES-1:0] ovf_o
);

  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_S = NUM_SLICES / 2;

  logic [1:0]            shift;
  logic [IDX_W-1:0]      span_m1;
  logic [NUM_SLICES-1:0] cut;
  logic [DATA_W-1:0]     sum;
  logic [NUM_SLICES-1:0] cout;
  logic [DATA_W-1:0]     res_d;
  logic [NUM_SLICES-1:0] ovf_d;

  psimd_lane_map #(.NUM_SLICES(NUM_SLICES)) u_map (
    .lane_mode_i(lane_mode_i),
    .shift_o    (shift),
    .span_m1_o  (span_m1),
    .cut_o      (cut)
  );

  psimd_carry_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chain (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_i),
    .cut_i (cut),
    .sum_o (sum),
    .cout_o(cout)
  );

  psimd_lane_ctl #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_ctl (
    .a_i      (a_i),
    .b_i      (b_i),
    .sum_i    (sum),
    .cout_i   (cout),
    .shift_i  (shift),
    .span_m1_i(span_m1),
    .sub_i    (sub_i),
    .sat_i    (sat_i),
    .signed_i (signed_i),
    .res_o    (res_d),
    .ovf_o    (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      ovf_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        ovf_o    <= ovf_d;
      end
    end
  end

  AST_OUT_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R9
  AST_OUT_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(ovf_o))); // R9
  AST_WRAP_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode_i == 2'd0 && !sat_i && !sub_i)
    |=> result_o[SLICE_W-1:0] == $past(SLICE_W'(a_i[SLICE_W-1:0] + b_i[SLICE_W-1:0]))); // R3
  AST_USUB_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode_i == 2'd0 && sat_i && !signed_i && sub_i &&
     (a_i[SLICE_W-1:0] < b_i[SLICE_W-1:0]))
    |=> (result_o[SLICE_W-1:0] == '0) && ovf_o[0]); // R6
  AST_MIXED_SIGN_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode_i == 2'd0 && signed_i && !sub_i &&
     (a_i[SLICE_W-1] != b_i[SLICE_W-1]))
    |=> !ovf_o[0]); // R5
  AST_UPPER_LANE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode_i[1] && !sat_i && !sub_i)
    |=> result_o[DATA_W-1:HALF_W] == $past(HALF_W'(a_i[DATA_W-1:HALF_W] + b_i[DATA_W-1:HALF_W]))); // R1
  AST_WIDE_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && lane_mode_i != 2'd0)
    |=> ovf_o[NUM_SLICES-1:HALF_S] == '0); // R8

endmodule

// File: tb/psimd_add_bench.sv
`timescale 1ns/1ps
module psimd_add_bench;

  localparam int VW = 205;
  localparam int NV = 15;

  // {mode[2], sub, sat, sgn, a[64], b[64], exp_res[64], exp_ovf[8]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'h01},
    {2'd1,1'b0,1'b0,1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0100, 8'h00},
    {2'd2,1'b0,1'b0,1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'h01},
    {2'd0,1'b1,1'b0,1'b0, 64'h0000_0000_0000_0305, 64'h0000_0000_0000_0501, 64'h0000_0000_0000_FE04, 8'h02},
    {2'd0,1'b0,1'b1,1'b0, 64'hF000_0000_0000_00F0, 64'h2000_0000_0000_0005, 64'hFF00_0000_0000_00F5, 8'h80},
    {2'd1,1'b1,1'b1,1'b0, 64'h0000_0000_0001_0010, 64'h0000_0000_0002_0001, 64'h0000_0000_0000_000F, 8'h02},
    {2'd0,1'b0,1'b0,1'b1, 64'h0000_0000_007F_807F, 64'h0000_0000_0080_FF01, 64'h0000_0000_00FF_7F80, 8'h03},
    {2'd0,1'b0,1'b1,1'b1, 64'h0000_0000_007F_807F, 64'h0000_0000_0080_FF01, 64'h0000_0000_00FF_807F, 8'h03},
    {2'd0,1'b1,1'b1,1'b1, 64'h0000_0000_8005_807F, 64'h0000_0000_8003_01FF, 64'h0000_0000_0002_807F, 8'h03},
    {2'd2,1'b0,1'b1,1'b1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 8'h03},
    {2'd1,1'b1,1'b1,1'b1, 64'h8000_0000_0000_7FFF, 64'h0001_0000_0000_8000, 64'h8000_0000_0000_7FFF, 8'h09},
    {2'd3,1'b0,1'b0,1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 8'h01},
    {2'd0,1'b0,1'b1,1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF},
    {2'd0,1'b1,1'b0,1'b1, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h80},
    {2'd2,1'b1,1'b0,1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF, 8'h01}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  lane_mode_i = '0;
  logic        sub_i = 1'b0;
  logic        sat_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic [7:0]  ovf_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk_i = ~clk_i;

  psimd_add u_psimd_add (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .lane_mode_i(lane_mode_i),
    .sub_i      (sub_i),
    .sat_i      (sat_i),
    .signed_i   (signed_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .out_valid_o(out_valid_o),
    .result_o   (result_o),
    .ovf_o      (ovf_o)
  );

  function automatic string vec_req(int idx);
    case (idx)
      0:        return "R4";
      1, 2, 11: return "R1";
      3, 14:    return "R2";
      4, 5:     return "R6";
      6:        return "R5";
      7, 8, 9:  return "R7";
      13:       return "R3";
      default:  return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fails++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [63:0] last_res;
    logic [7:0]  last_ovf;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", "valid in reset", 64'(out_valid_o), 64'd0);
    check("R10", "result in reset", result_o, 64'd0);
    check("R10", "flags in reset", 64'(ovf_o), 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {lane_mode_i, sub_i, sat_i, signed_i, a_i, b_i} = VEC[i][VW-1:72];
      in_valid_i = 1'b1;
      @(negedge clk_i);
      check("R9", "out_valid", 64'(out_valid_o), 64'd1);
      check(vec_req(i), $sformatf("vec %0d result", i), result_o, VEC[i][71:8]);
      check(vec_req(i), $sformatf("vec %0d flags", i), 64'(ovf_o), 64'(VEC[i][7:0]));
    end
    last_res = VEC[NV-1][71:8];
    last_ovf = VEC[NV-1][7:0];

    // R9: idle cycle drops valid and holds outputs despite new operands
    in_valid_i  = 1'b0;
    lane_mode_i = 2'd0;
    sat_i       = 1'b1;
    a_i         = '1;
    b_i         = '1;
    @(negedge clk_i);
    check("R9", "valid after idle", 64'(out_valid_o), 64'd0);
    check("R9", "result held", result_o, last_res);
    check("R9", "flags held", 64'(ovf_o), 64'(last_ovf));
    @(negedge clk_i);
    check("R9", "result still held", result_o, last_res);

    // R3: wrap mode on a full unsigned byte overflow across all lanes
    {lane_mode_i, sub_i, sat_i, signed_i} = {2'd0, 1'b0, 1'b0, 1'b0};
    a_i = 64'h8080_8080_8080_8080;
    b_i = 64'h8181_8181_8181_8181;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    check("R3", "wrap all lanes", result_o, 64'h0101_0101_0101_0101);
    check("R8", "all flags wrap", 64'(ovf_o), 64'hFF);
    in_valid_i = 1'b0;

    // R10: asynchronous reset mid-run clears outputs
    #1 rst_ni = 1'b0;
    #1;
    check("R10", "valid after reset", 64'(out_valid_o), 64'd0);
    check("R10", "result after reset", result_o, 64'd0);
    check("R10", "flags after reset", 64'(ovf_o), 64'd0);
    summary();
  end

endmodule